// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small CPU: two external request pins (active low), two timer overflow flags and one serial-port source built from a transmit flag and a receive flag. Each source has its own enable bit, and a global enable gates all five. Each source also has a priority bit that puts it in the high level; within a level the fixed natural order decides. The winning request goes to the CPU together with its vector address.

The external pins are captured either on a falling edge or by level, per pin. When the CPU accepts a request with a one-cycle acknowledge pulse, the block latches the vector and the source number and marks the request's level as in service. The block then holds off requests of that level and below until a return pulse. An accepted edge-captured request has its flag cleared at once. An accepted timer request produces a one-cycle clear strobe to that timer on the next cycle. The serial source is never cleared by the block.

Top module: `irq2_ctrl`

## Requirements
- R1: Source numbers are external-0 = 0, timer-0 = 1, external-1 = 2, timer-1 = 3, serial = 4. Within one priority level, the pending source with the smallest number wins.
- R2: A source is pending only if its flag is set, its bit in `src_en` is 1 and `glb_en` is 1. With `glb_en` at 0, `irq_req` stays 0.
- R3: A source whose bit in `prio_hi` is 1 is in the high level and wins over every low-level source, whatever their numbers.
- R4: The active level is 2 if `in_svc[1]` is set, 1 if only `in_svc[0]` is set, and 0 otherwise. A request level is 2 for the high level and 1 for the low level. `irq_req` is 1 only when the winner's level is above the active level, so same-or-lower requests are blocked while a handler runs.
- R5: After reset `in_svc` is 0. A `reti` pulse clears the highest set bit of `in_svc`: bit 1 if it is set, otherwise bit 0.
- R6: With `ext_edge[k]` = 1, a 1-to-0 transition on `ext_n[k]` sets that pin's flag one clock later. The flag holds until the request is accepted. A rising edge or a pin held low sets nothing further. A new falling edge in the accept cycle wins over the clear.
- R7: With `ext_edge[k]` = 0, the pin's flag is the inverse of `ext_n[k]` registered once. Accepting the request does not clear it.
- R8: `irq_vec` is 0x0003 + 8 × winner number while `irq_req` is 1, and 0 otherwise.
- R9: On a clock edge with `ack` = 1 and `irq_req` = 1, `svc_vec` and `svc_src` take the current vector and winner number, and the winner's level bit is set in `in_svc`. An `ack` while `irq_req` = 0 changes nothing.
- R10: Accepting timer-j raises `tmr_clr[j]` for exactly the following cycle. At most one clear bit is high at a time, and no other event raises one.
- R11: The serial flag is `ser_tx | ser_rx` and is never cleared by an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per pin: 1 = falling-edge capture, 0 = level capture |
| tmr_flag | input | 2 | Timer overflow flags, held by the timers |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| src_en | input | 5 | Per-source enable, indexed by source number |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 5 | Per-source high-level bit |
| ack | input | 1 | CPU accepts the current request (one-cycle pulse) |
| reti | input | 1 | CPU returns from a handler (one-cycle pulse) |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector of the current winner |
| svc_vec | output | 16 | Vector latched at the last accept |
| svc_src | output | 3 | Source number latched at the last accept |
| in_svc | output | 2 | In-service bits: [1] high level, [0] low level |
| tmr_clr | output | 2 | One-cycle clear strobes to the timers |

## Verification
A wrong in-service bit shows up at once as a request that should nest but does not, or a request that should be blocked but is not. It also shows in `in_svc` on the cycle after the accept or return that caused it. A stale or early-cleared external flag changes `irq_req` and `irq_vec` one cycle after the faulty pin sample or accept. A wrong clear strobe leaves a timer flag set, so the same vector comes back after the next return. The bench compares every output against its own model on every cycle, so each such fault is caught in the cycle it first appears.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  localparam int NSRC     = 5;
  localparam int IDXW     = $clog2(NSRC);
  localparam int VECW     = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int NEXT     = 2;
  localparam int NTMR     = 2;

  // vector address of a source number
  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VECW'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction

  // lowest set bit number of a source mask (0 when empty)
  function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] m);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (m[i]) r = IDXW'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq2_ext_cap.sv
module irq2_ext_cap #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] edge_mode,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] flag
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] fall;

  assign fall = prev_q & ~pin_n;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[k] <= 1'b1;
        flag[k]   <= 1'b0;
      end else begin
        prev_q[k] <= pin_n[k];
        if (!edge_mode[k])  flag[k] <= ~pin_n[k];
        else if (fall[k])   flag[k] <= 1'b1;
        else if (clr[k])    flag[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq2_pick.sv
module irq2_pick
  import irq2_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] hi,
  input  logic [1:0]      act_lvl,
  output logic            req,
  output logic [IDXW-1:0] idx,
  output logic            win_hi
);
  logic [NSRC-1:0] hi_m;
  logic [NSRC-1:0] lo_m;
  logic [1:0]      win_lvl;

  assign hi_m    = pend & hi;
  assign lo_m    = pend & ~hi;
  assign win_hi  = |hi_m;
  assign idx     = win_hi ? first_set(hi_m) : first_set(lo_m);
  assign win_lvl = win_hi ? 2'd2 : 2'd1;
  assign req     = (|pend) && (win_lvl > act_lvl);
endmodule

// File: rtl/irq2_svc.sv
module irq2_svc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       reti,
  output logic [1:0] in_svc,
  output logic [1:0] act_lvl
);
  logic [1:0] after_ret;

  always_comb begin
    after_ret = in_svc;
    if (reti) begin
      if (in_svc[1]) after_ret[1] = 1'b0;
      else           after_ret[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_svc <= 2'b00;
    else        in_svc <= after_ret | (take ? (take_hi ? 2'b10 : 2'b01) : 2'b00);
  end

  assign act_lvl = in_svc[1] ? 2'd2 : (in_svc[0] ? 2'd1 : 2'd0);
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
  import irq2_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NEXT-1:0]     ext_n,
  input  logic [NEXT-1:0]     ext_edge,
  input  logic [NTMR-1:0]     tmr_flag,
  input  logic                ser_tx,
  input  logic                ser_rx,
  input  logic [NSRC-1:0]     src_en,
  input  logic                glb_en,
  input  logic [NSRC-1:0]     prio_hi,
  input  logic                ack,
  input  logic                reti,
  output logic                irq_req,
  output logic [VECW-1:0]     irq_vec,
  output logic [VECW-1:0]     svc_vec,
  output logic [IDXW-1:0]     svc_src,
  output logic [1:0]          in_svc,
  output logic [NTMR-1:0]     tmr_clr
);
  logic [NEXT-1:0] ext_flag;
  logic [NEXT-1:0] ext_clr;
  logic [NTMR-1:0] tmr_take;
  logic [NSRC-1:0] src_flag;
  logic [NSRC-1:0] pend;
  logic [IDXW-1:0] win_idx;
  logic            win_hi;
  logic [1:0]      act_lvl;
  logic            take;

  // source numbering: ext0, tmr0, ext1, tmr1, serial
  assign src_flag = {ser_tx | ser_rx, tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};
  assign pend     = src_flag & src_en & {NSRC{glb_en}};
  assign take     = ack & irq_req;

  for (genvar k = 0; k < NEXT; k++) begin : g_eclr
    assign ext_clr[k] = take && (win_idx == IDXW'(2 * k));
  end
  for (genvar j = 0; j < NTMR; j++) begin : g_tclr
    assign tmr_take[j] = take && (win_idx == IDXW'(2 * j + 1));
  end

  irq2_ext_cap #(.NPIN(NEXT)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_n), .edge_mode(ext_edge),
    .clr(ext_clr), .flag(ext_flag)
  );

  irq2_pick u_pick (
    .pend(pend), .hi(prio_hi), .act_lvl(act_lvl),
    .req(irq_req), .idx(win_idx), .win_hi(win_hi)
  );

  irq2_svc u_svc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(win_hi), .reti(reti),
    .in_svc(in_svc), .act_lvl(act_lvl)
  );

  assign irq_vec = irq_req ? vec_of(win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_vec <= '0;
      svc_src <= '0;
      tmr_clr <= '0;
    end else begin
      tmr_clr <= tmr_take;
      if (take) begin
        svc_vec <= irq_vec;
        svc_src <= win_idx;
      end
    end
  end
endmodule

// File: rtl/irq2_chk.sv
module irq2_chk
  import irq2_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            reti,
  input logic            glb_en,
  input logic            irq_req,
  input logic [VECW-1:0] irq_vec,
  input logic [VECW-1:0] svc_vec,
  input logic [1:0]      in_svc,
  input logic [NTMR-1:0] tmr_clr
);
  AST_NO_GLB_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req); // R2
  AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq_req); // R4
  AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && in_svc != 2'b00) |=> ($countones(in_svc) + 1 == $countones($past(in_svc)))); // R5
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0); // R8
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req) |=> $stable(svc_vec)); // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_clr)); // R10
  AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr != '0) |-> $past(ack && irq_req)); // R10
endmodule

bind irq2_ctrl irq2_chk u_chk (.*);

// File: tb/tb_irq2_ctrl.sv
`timescale 1ns/100ps
module tb_irq2_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ext_n = 2'b11, ext_edge = 2'b11, tmr_flag = 0;
  logic        ser_tx = 0, ser_rx = 0;
  logic [4:0]  src_en = 0, prio_hi = 0;
  logic        glb_en = 0, ack = 0, reti = 0;
  logic        irq_req;
  logic [15:0] irq_vec, svc_vec;
  logic [2:0]  svc_src;
  logic [1:0]  in_svc, tmr_clr;

  irq2_ctrl dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R5";

  // model state
  bit mprev[2], mext[2], mtclr[2];
  bit msvc[2];
  int msvec = 0, msrc = 0;
  bit mreq; int mwin; bit mhi;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_comb();
    bit f[5]; int best; int act; int lvl;
    f[0] = mext[0]; f[1] = tmr_flag[0]; f[2] = mext[1]; f[3] = tmr_flag[1];
    f[4] = ser_tx || ser_rx;
    best = 99; mwin = 0;
    for (int i = 0; i < 5; i++)
      if (f[i] && src_en[i] && glb_en) begin
        int sc = (prio_hi[i] ? 0 : 10) + i;
        if (sc < best) begin best = sc; mwin = i; end
      end
    mhi = (best < 10);
    lvl = mhi ? 2 : 1;
    act = msvc[1] ? 2 : (msvc[0] ? 1 : 0);
    mreq = (best != 99) && (lvl > act);
  endtask

  task automatic model_seq();
    bit take = ack && mreq;
    for (int k = 0; k < 2; k++) begin
      bit fall = mprev[k] && !ext_n[k];
      if (!ext_edge[k]) mext[k] = !ext_n[k];
      else if (fall) mext[k] = 1;
      else if (take && mwin == 2*k) mext[k] = 0;
      mprev[k] = ext_n[k];
    end
    for (int j = 0; j < 2; j++) begin
      if (mtclr[j]) tmr_flag[j] = 0;  // bench timer honours its clear strobe
      mtclr[j] = take && (mwin == 2*j + 1);
    end
    if (reti) begin
      if (msvc[1]) msvc[1] = 0; else msvc[0] = 0;
    end
    if (take) begin
      msvc[mhi ? 1 : 0] = 1;
      msvec = 3 + 8*mwin; msrc = mwin;
    end
  endtask

  // inputs already set at a falling edge; compare, then advance one clock
  task automatic tick();
    #1;
    model_comb();
    chk(irq_req == mreq, "irq_req", irq_req, mreq);
    chk(irq_vec == (mreq ? 3 + 8*mwin : 0), "irq_vec R8", irq_vec, mreq ? 3 + 8*mwin : 0);
    chk(svc_vec == msvec && svc_src == msrc, "svc_vec/src R9", {svc_vec, 1'b0, svc_src}, {msvec[15:0], 1'b0, msrc[2:0]});
    chk(in_svc == {msvc[1], msvc[0]}, "in_svc R5", in_svc, {msvc[1], msvc[0]});
    chk(tmr_clr == {mtclr[1], mtclr[0]}, "tmr_clr R10", tmr_clr, {mtclr[1], mtclr[0]});
    @(posedge clk);
    model_seq();
    @(negedge clk);
    ack = 0; reti = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic accept(); ack = 1; tick(); run(2); endtask
  task automatic ret();    reti = 1; tick(); run(1); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mprev[0] = 1; mprev[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R5"; run(2);                      // reset state

    // R1: natural order within the low level
    tag = "R1"; src_en = 5'h1F; glb_en = 1;
    tmr_flag = 2'b11; ext_n[1] = 0; run(2);
    accept();                                // timer0 wins, vec 0x0B
    tag = "R10"; ret();
    tag = "R6"; accept();                    // ext1 edge flag cleared
    ret();
    tag = "R1"; accept(); ret();             // timer1
    tag = "R6"; ext_n[1] = 1; run(2); run(2);  // rising edge sets nothing

    // R2: global and per-source masking
    tag = "R2"; tmr_flag[1] = 1; glb_en = 0; run(2);
    glb_en = 1; src_en[3] = 0; run(2);
    src_en[3] = 1; run(1);

    // R3/R4: high level nests over a low handler
    tag = "R4"; accept();                    // timer1 low in service
    ser_rx = 1; run(2);                      // serial low: blocked
    tag = "R3"; prio_hi[4] = 1; run(1);
    accept();                                // serial high nests
    tag = "R4"; prio_hi[0] = 1; ext_n[0] = 0; run(2); // ext0 high blocked
    tag = "R5"; ret();                       // clears high bit only
    tag = "R3"; accept();                    // ext0 high (edge) now
    tag = "R5"; ret(); ret();

    // R11: serial flag not cleared by accept
    tag = "R11"; ext_n[0] = 1; prio_hi = 0; ser_rx = 0; ser_tx = 1; run(1);
    accept(); ret(); run(1);
    ser_tx = 0; run(2);

    // R7: level capture persists through accept
    tag = "R7"; ext_edge[1] = 0; ext_n[1] = 0; run(2);
    accept(); ret(); run(1);
    ext_n[1] = 1; run(2);

    // R9: ack with nothing pending
    tag = "R9"; ack = 1; tick(); run(2);

    // R6: falling edge coinciding with accept of same pin
    tag = "R6"; ext_n[0] = 0; run(2);
    ext_n[0] = 1; run(1);
    ext_n[0] = 0; accept(); ret(); run(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule